// File: doc/BRIEF.md
# Hiccup Fault Supervisor with Power-Good

This block supervises start-up and fault recovery for a synchronous step-down converter controller. Digital fault flags for supply undervoltage, input undervoltage, over-temperature and overcurrent arrive from analog comparators and are resynchronised on entry. A short circuit is detected inside the block by comparing a digital feedback code with the active reference. The block owns a soft-start ramp counter and a hiccup timer. It produces the soft-start code, the active regulation reference, a driver-inhibit signal, a compensation-clamp signal and an open-drain style power-good pull-down.

After reset, and while enable is low, the block sleeps. Once enabled it ramps the soft-start code from zero. Any fault sends it to an idle hiccup period of a fixed number of clock cycles. In that period the drivers are inhibited, the compensation node is clamped and soft-start is discharged. A short circuit or an overcurrent is released when the timer expires, so a persistent short produces one retry per period. Undervoltage and thermal faults also hold the block idle until their flags have gone away.

Top module: `hiccup_supervisor`

## Requirements
- R1: While reset is asserted and on leaving it, `drv_off` and `comp_clamp` are 1, `ss_code` and `ref_code` are 0, and `pg_pull_low` is 1.
- R2: Each raw flag passes through a two-flop synchroniser, so a fault flag that changes between two clock edges acts at the third rising edge after the change. At that edge `drv_off` and `comp_clamp` go to 1, `ss_code` goes to 0 and `pg_pull_low` goes to 1.
- R3: A fault that is not held (overcurrent, short circuit) keeps `drv_off` high for exactly `HICCUP_CYC` cycles, and then a restart begins with `ss_code` at 0.
- R4: A supply undervoltage, input undervoltage or thermal flag that is still present keeps the block idle past the timeout. Once the flag is removed and the timeout has expired, drivers are released at the third rising edge after the removal.
- R5: If overcurrent persists, each hiccup period of `HICCUP_CYC` cycles is followed by a one-cycle restart attempt. After the flag clears, operation resumes.
- R6: While running, a short circuit is taken when `fb_code + SC_DELTA < ref_code`, where `SC_DELTA = REF_CODE*5/16` (0.25 V against a 0.8 V reference). The block goes idle at the next rising edge. Because the reference follows soft-start, detection also works during the ramp.
- R7: While running, `ss_code` rises by `SS_STEP` once every `TICK_DIV` cycles, starting `TICK_DIV` cycles after entry. It saturates at `2**CODE_W-1`, and `ref_code = min(ss_code, REF_CODE)`.
- R8: `pg_pull_low` stays 1 unless the block is running with `ss_code >= 2*REF_CODE`. The pull-down may release at the same edge at which `ss_code` reaches that gate.
- R9: Once gated, power-good has hysteresis with a one-cycle latency: the pull-down releases when `fb_code >= REF_CODE*37/40`, reasserts when `fb_code < REF_CODE*9/10`, and otherwise holds.
- R10: Driving `en` low puts the block to sleep at the third rising edge after the change, with drivers off, `ss_code` at 0 and power-good pulled low. Raising `en` with no faults present starts a fresh soft-start at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable, asynchronous; low means sleep |
| vcc_low | input | 1 | Bias supply undervoltage flag, asynchronous |
| vin_low | input | 1 | Input supply undervoltage flag, asynchronous |
| hot | input | 1 | Over-temperature flag, asynchronous |
| ovc | input | 1 | Overcurrent flag, asynchronous |
| fb_code | input | CODE_W | Digitised output feedback |
| ss_code | output | CODE_W | Soft-start ramp code |
| ref_code | output | CODE_W | Active reference, min(soft-start, REF_CODE) |
| drv_off | output | 1 | Inhibit both gate drivers |
| comp_clamp | output | 1 | Pull the compensation node low |
| pg_pull_low | output | 1 | Power-good open-drain pull-down, 1 = pin pulled low |

## Verification
The hardest case to reach from the ports is a short circuit caught partway up the ramp. It needs the feedback to lag a reference that is still rising, and the restart window then depends on the tick spacing as well as the trip margin. The bench first sweeps the feedback across the trip boundary with the reference settled. It then holds the feedback at zero through two hiccup periods and checks that the running window after each timeout has the length worked out from the step size, the tick spacing and the margin. Held faults are checked in a second way: each one is kept present well past the timeout, and the release edge is counted from the moment the flag is removed.

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor #(
  parameter int CODE_W     = 10,
  parameter int REF_CODE   = 320,
  parameter int SS_STEP    = 1,
  parameter int TICK_DIV   = 250,
  parameter int HICCUP_CYC = 37_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              vcc_low,
  input  logic              vin_low,
  input  logic              hot,
  input  logic              ovc,
  input  logic [CODE_W-1:0] fb_code,
  output logic [CODE_W-1:0] ss_code,
  output logic [CODE_W-1:0] ref_code,
  output logic              drv_off,
  output logic              comp_clamp,
  output logic              pg_pull_low
);
  localparam int W1       = CODE_W + 1;
  localparam int SC_DELTA = REF_CODE * 5 / 16;
  localparam int PG_ON    = REF_CODE * 37 / 40;
  localparam int PG_OFF   = REF_CODE * 9 / 10;
  localparam int PG_GATE  = 2 * REF_CODE;
  localparam int SS_MAX   = (1 << CODE_W) - 1;
  localparam int TW       = $clog2(HICCUP_CYC + 1);
  localparam int PW       = $clog2(TICK_DIV + 1);

  localparam logic [1:0] ST_SLEEP = 2'd0;
  localparam logic [1:0] ST_RUN   = 2'd1;
  localparam logic [1:0] ST_HIC   = 2'd2;

  logic [4:0]        m1, m2;
  logic [1:0]        state, nxt;
  logic [TW-1:0]     tmr;
  logic [PW-1:0]     pre;
  logic [CODE_W-1:0] ss_nxt, ss_inc;
  logic [W1-1:0]     ss_sum;
  logic              pg_ok, pg_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1 <= '0;
      m2 <= '0;
    end else begin
      m1 <= {en, ovc, hot, vin_low, vcc_low};
      m2 <= m1;
    end

  wire hold_flt = m2[0] | m2[1] | m2[2];
  wire oc_s     = m2[3];
  wire en_s     = m2[4];
  wire tmr_done = (tmr == TW'(HICCUP_CYC - 1));
  wire tick     = (pre == PW'(TICK_DIV - 1));
  wire sc       = (state == ST_RUN) &&
                  (int'(fb_code) + SC_DELTA < int'(ref_code));

  always_comb begin
    nxt = state;
    case (state)
      ST_SLEEP: nxt = (hold_flt | oc_s) ? ST_HIC : ST_RUN;
      ST_RUN:   if (hold_flt | oc_s | sc) nxt = ST_HIC;
      ST_HIC:   if (tmr_done && !hold_flt) nxt = ST_RUN;
      default:  nxt = ST_SLEEP;
    endcase
    if (!en_s) nxt = ST_SLEEP;
  end

  assign ss_sum = {1'b0, ss_code} + W1'(SS_STEP);
  assign ss_inc = (int'(ss_sum) > SS_MAX) ? CODE_W'(SS_MAX) : ss_sum[CODE_W-1:0];

  always_comb begin
    if (nxt != ST_RUN)                 ss_nxt = '0;
    else if (state == ST_RUN && tick)  ss_nxt = ss_inc;
    else                               ss_nxt = ss_code;
  end

  assign pg_nxt = (nxt == ST_RUN) && (int'(ss_nxt) >= PG_GATE) &&
                  ((int'(fb_code) >= PG_ON) || (pg_ok && int'(fb_code) >= PG_OFF));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= ST_SLEEP;
      tmr     <= '0;
      pre     <= '0;
      ss_code <= '0;
      pg_ok   <= 1'b0;
    end else begin
      state   <= nxt;
      ss_code <= ss_nxt;
      pg_ok   <= pg_nxt;
      if (state != ST_HIC)  tmr <= '0;
      else if (!tmr_done)   tmr <= tmr + 1'b1;
      if (state != ST_RUN || tick) pre <= '0;
      else                         pre <= pre + 1'b1;
    end

  assign ref_code    = (int'(ss_code) > REF_CODE) ? CODE_W'(REF_CODE) : ss_code;
  assign drv_off     = (state != ST_RUN);
  assign comp_clamp  = (state != ST_RUN);
  assign pg_pull_low = !pg_ok;
endmodule

// File: rtl/hiccup_supervisor_chk.sv
module hiccup_supervisor_chk #(
  parameter int CODE_W     = 10,
  parameter int REF_CODE   = 320,
  parameter int HICCUP_CYC = 37_500_000
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [1:0]                        state,
  input logic [$clog2(HICCUP_CYC+1)-1:0]   tmr,
  input logic [CODE_W-1:0]                 fb_code,
  input logic [CODE_W-1:0]                 ss_code,
  input logic [CODE_W-1:0]                 ref_code,
  input logic                              drv_off,
  input logic                              pg_pull_low
);
  localparam int SC_DELTA = REF_CODE * 5 / 16;
  localparam int PG_OFF   = REF_CODE * 9 / 10;
  localparam int PG_GATE  = 2 * REF_CODE;

  AST_IDLE_SS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    drv_off |-> ss_code == '0); // R2

  AST_SS_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_off && $past(!drv_off)) |-> ss_code >= $past(ss_code)); // R7

  AST_SC_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_off && (int'(fb_code) + SC_DELTA < int'(ref_code))) |=> drv_off); // R6

  AST_HICCUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && $past(state) == 2'd2) |-> int'($past(tmr)) == HICCUP_CYC - 1); // R3

  AST_PG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_pull_low |-> (!drv_off && int'(ss_code) >= PG_GATE)); // R8

  AST_PG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fb_code) < PG_OFF) |=> pg_pull_low); // R9
endmodule

bind hiccup_supervisor hiccup_supervisor_chk #(
  .CODE_W(CODE_W), .REF_CODE(REF_CODE), .HICCUP_CYC(HICCUP_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .tmr(tmr), .fb_code(fb_code),
  .ss_code(ss_code), .ref_code(ref_code), .drv_off(drv_off), .pg_pull_low(pg_pull_low)
);

// File: tb/hiccup_supervisor_tb.sv
module hiccup_supervisor_tb;
  localparam int W    = 8;
  localparam int REF  = 64;
  localparam int STEP = 4;
  localparam int TD   = 2;
  localparam int HC   = 40;
  localparam int DELTA = REF * 5 / 16;
  localparam int PGON  = REF * 37 / 40;
  localparam int PGOFF = REF * 9 / 10;
  localparam int GATE  = 2 * REF;
  localparam int SMAX  = (1 << W) - 1;

  logic clk = 0, rst_n = 0, en = 0, vcc_low = 0, vin_low = 0, hot = 0, ovc = 0;
  logic [W-1:0] fb_code = '0;
  logic [W-1:0] ss_code, ref_code;
  logic drv_off, comp_clamp, pg_pull_low;
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  hiccup_supervisor #(.CODE_W(W), .REF_CODE(REF), .SS_STEP(STEP), .TICK_DIV(TD),
                      .HICCUP_CYC(HC)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .vcc_low(vcc_low), .vin_low(vin_low), .hot(hot),
    .ovc(ovc), .fb_code(fb_code), .ss_code(ss_code), .ref_code(ref_code),
    .drv_off(drv_off), .comp_clamp(comp_clamp), .pg_pull_low(pg_pull_low));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_chk(input string req);
    chk({req, " drv_off"}, drv_off, 1);
    chk({req, " comp_clamp"}, comp_clamp, 1);
    chk({req, " ss_code"}, ss_code, 0);
    chk({req, " pg_pull_low"}, pg_pull_low, 1);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finished");
    summary();
  end

  initial begin
    int n, m, exp_ss, exp_ref;
    bit pg;
    fb_code = W'(REF);
    step(2);
    idle_chk("R1 in reset");
    chk("R1 ref_code", ref_code, 0);
    rst_n = 1;
    step(5);
    idle_chk("R1 after reset, en low");

    en = 1;
    step(2);
    chk("R10 enable latency edge2", drv_off, 1);
    step();
    chk("R10 enable latency edge3", drv_off, 0);
    for (int k = 0; k < 150; k++) begin
      exp_ss = (k / TD) * STEP;
      if (exp_ss > SMAX) exp_ss = SMAX;
      exp_ref = exp_ss > REF ? REF : exp_ss;
      chk("R7 ramp ss_code", ss_code, exp_ss);
      chk("R7 ramp ref_code", ref_code, exp_ref);
      chk("R8 power-good gate", pg_pull_low, exp_ss >= GATE ? 0 : 1);
      step();
    end

    pg = 1;
    for (int f = REF; f >= DELTA + REF - DELTA - 19 && f >= 45; f--) begin
      fb_code = W'(f);
      step();
      if (f >= PGON) pg = 1; else if (f < PGOFF) pg = 0;
      chk("R9 hysteresis down", pg_pull_low, !pg);
    end
    for (int f = 45; f <= REF; f++) begin
      fb_code = W'(f);
      step();
      if (f >= PGON) pg = 1; else if (f < PGOFF) pg = 0;
      chk("R9 hysteresis up", pg_pull_low, !pg);
    end

    ovc = 1;
    step();
    ovc = 0;
    step();
    chk("R2 overcurrent latency edge2", drv_off, 0);
    step();
    idle_chk("R2 overcurrent taken");
    n = 0;
    while (drv_off) begin n++; step(); end
    chk("R3 hiccup length", n, HC);
    chk("R3 restart from zero ss_code", ss_code, 0);
    chk("R3 restart pg_pull_low", pg_pull_low, 1);

    step(20);
    ovc = 1;
    step(3);
    for (int p = 0; p < 3; p++) begin
      n = 0;
      while (drv_off) begin n++; step(); end
      chk("R5 persistent overcurrent off window", n, HC);
      m = 0;
      while (!drv_off) begin m++; step(); end
      chk("R5 persistent overcurrent retry window", m, 1);
    end
    ovc = 0;
    step(2 * HC + 10);
    chk("R5 recovery after overcurrent clears", drv_off, 0);

    for (int kind = 0; kind < 3; kind++) begin
      step(10);
      if (kind == 0) vcc_low = 1; else if (kind == 1) vin_low = 1; else hot = 1;
      step(3);
      idle_chk("R4 held fault entry");
      for (int c = 0; c < HC + 20; c++) begin
        chk("R4 held fault keeps idle", drv_off, 1);
        step();
      end
      vcc_low = 0; vin_low = 0; hot = 0;
      step(2);
      chk("R4 release edge2", drv_off, 1);
      step();
      chk("R4 release edge3", drv_off, 0);
    end

    fb_code = W'(REF);
    step(150);
    chk("R6 settled ref_code", ref_code, REF);
    fb_code = W'(REF - DELTA);
    for (int c = 0; c < 5; c++) begin
      step();
      chk("R6 at margin, no trip", drv_off, 0);
    end
    fb_code = W'(REF - DELTA - 1);
    step();
    idle_chk("R6 trip one below margin");
    fb_code = '0;
    for (int p = 0; p < 2; p++) begin
      n = 0;
      while (drv_off) begin n++; step(); end
      chk("R6 short hiccup length", n, HC);
      m = 0;
      while (!drv_off) begin m++; step(); end
      chk("R6 trip during soft start window", m, (DELTA / STEP + 1) * TD + 1);
    end
    fb_code = W'(REF);
    step(2 * HC + 150);
    chk("R6 recovery drv_off", drv_off, 0);
    chk("R6 recovery pg_pull_low", pg_pull_low, 0);

    en = 0;
    step(2);
    chk("R10 disable edge2", drv_off, 0);
    step();
    idle_chk("R10 sleep");
    ovc = 1;
    step(10);
    idle_chk("R10 sleep with fault");
    ovc = 0;

    summary();
  end
endmodule